// File: doc/BRIEF.md
# Pseudo-Random Stimulus Source

This block produces a fixed-length stream of pseudo-random messages on a ready/valid output channel. It is meant to drive a device under test in a hardware-resident verification loop. A 16-bit shift register with Galois feedback generates each payload. A counter limits the stream to a number of messages set by a parameter. When the last message has been accepted, a sticky completion flag rises.

The block never assumes the consumer is ready. While a message is offered and not taken, both the payload and the generator state stay frozen. The generator steps only on an accepted transfer, so the consumer sees the same message sequence under any backpressure pattern. Reset is the only control: after reset the stream restarts from the seed.

Top module: `stim_source`

## Requirements
- R1: The active-low reset `rstN` is asynchronous. While it is low, `outValid` and `streamDone` are 0.
- R2: The first message offered after reset equals the parameter `SEED`, which is nonzero (default 16'hACE1). The 16-bit value is zero-extended to 32 bits.
- R3: Each accepted message is followed by the Galois step of the previous value: shift right by one, then, if the bit shifted out was 1, XOR with `TAPS` (default 16'hB400). Bits 31:16 of `outData` are always 0.
- R4: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged on the next cycle.
- R5: The generator advances only on a cycle where `outValid` and `outReady` are both 1. Stall cycles of any length leave the sequence unchanged.
- R6: Exactly `NUM_MSGS` messages (default 256) are accepted. After that, `outValid` stays 0 whatever `outReady` does.
- R7: `streamDone` rises in the cycle after the last message is accepted and stays 1 until reset.
- R8: A reset applied in the middle of a stream restarts the identical sequence from `SEED` with a fresh message count.
- R9: `outValid` rises at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| outValid | output | 1 | A message is offered |
| outReady | input | 1 | The consumer takes the offered message |
| outData | output | 32 | Message payload, generator state zero-extended |
| streamDone | output | 1 | All messages have been accepted (sticky) |

## Verification
The hardest behaviour to reach from the ports is the end of the stream under irregular backpressure. Reaching it needs all 256 transfers, mixed with stalls of varied length, and then `outReady` held high after completion to show that nothing more appears. The stimulus opens with a long directed stall on the very first message. It then runs a full-throughput stretch and a seeded random ready pattern. The bench's own model of the shift register predicts every payload. A second reset is applied partway through a later stream to show that the sequence restarts.

// File: rtl/stim_pkg.sv
`timescale 1ns/1ps
package stim_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // accepted transfer this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/stim_ctrl.sv
`timescale 1ns/1ps
module stim_ctrl
  import stim_pkg::*;
#(
  parameter int unsigned NUM_MSGS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        outReady,
  output logic        outValid,
  output logic        streamDone,
  output ctrlStrobe_t strobe
);
  localparam int unsigned CNT_W = (NUM_MSGS > 2) ? $clog2(NUM_MSGS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_MSGS - 1);

  logic [CNT_W-1:0] sentCnt;
  logic             validQ;
  logic             doneQ;
  logic             fire;

  assign fire           = validQ && outReady;
  assign strobe.advance = fire;
  assign outValid       = validQ;
  assign streamDone     = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sentCnt <= '0;
      validQ  <= 1'b0;
      doneQ   <= 1'b0;
    end else if (!doneQ) begin
      if (!validQ) begin
        validQ <= 1'b1;
      end else if (fire) begin
        if (sentCnt == LAST_IDX) begin
          validQ <= 1'b0;
          doneQ  <= 1'b1;
        end else begin
          sentCnt <= sentCnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stim_lfsr_dp.sv
`timescale 1ns/1ps
module stim_lfsr_dp
  import stim_pkg::*;
#(
  parameter int unsigned   LFSR_W = 16,
  parameter int unsigned   MSG_W  = 32,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic [MSG_W-1:0] outData
);
  localparam int unsigned PAD_W = MSG_W - LFSR_W;

  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNext;

  always_comb begin
    lfsrNext = lfsrQ >> 1;
    if (lfsrQ[0]) lfsrNext = lfsrNext ^ TAPS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lfsrQ <= SEED;
    else if (strobe.advance) lfsrQ <= lfsrNext;
  end

  generate
    if (PAD_W > 0) begin : gPad
      assign outData = {{PAD_W{1'b0}}, lfsrQ};
    end else begin : gNoPad
      assign outData = lfsrQ[MSG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/stim_source.sv
`timescale 1ns/1ps
module stim_source
  import stim_pkg::*;
#(
  parameter int unsigned   NUM_MSGS = 256,
  parameter int unsigned   LFSR_W   = 16,
  parameter int unsigned   MSG_W    = 32,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic             clk,
  input  logic             rstN,
  output logic             outValid,
  input  logic             outReady,
  output logic [MSG_W-1:0] outData,
  output logic             streamDone
);
  ctrlStrobe_t strobe;

  stim_ctrl #(.NUM_MSGS(NUM_MSGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .outReady(outReady),
    .outValid(outValid), .streamDone(streamDone), .strobe(strobe)
  );

  stim_lfsr_dp #(.LFSR_W(LFSR_W), .MSG_W(MSG_W), .SEED(SEED), .TAPS(TAPS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .outData(outData)
  );
endmodule

// File: rtl/stim_source_chk.sv
`timescale 1ns/1ps
module stim_source_chk #(
  parameter int unsigned NUM_MSGS = 256,
  parameter int unsigned MSG_W    = 32,
  parameter int unsigned LFSR_W   = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic             outReady,
  input logic [MSG_W-1:0] outData,
  input logic             streamDone
);
  localparam int unsigned FC_W = $clog2(NUM_MSGS + 1) + 1;
  logic [FC_W-1:0] fireCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fireCnt <= '0;
    else if (outValid && outReady) fireCnt <= fireCnt + 1'b1;
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid); // R4
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> $stable(outData)); // R4
  AST_NONZERO_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outData != '0); // R2
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    outData[MSG_W-1:LFSR_W] == '0); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    streamDone |=> streamDone); // R7
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    streamDone |-> !outValid); // R6
  AST_EXACT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    streamDone |-> fireCnt == FC_W'(NUM_MSGS)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fireCnt <= FC_W'(NUM_MSGS)); // R6
endmodule

bind stim_source stim_source_chk #(.NUM_MSGS(NUM_MSGS), .MSG_W(MSG_W), .LFSR_W(LFSR_W)) u_chk (
  .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
  .outData(outData), .streamDone(streamDone)
);

// File: tb/stim_source_bench.sv
`timescale 1ns/1ps
module stim_source_bench;
  localparam int unsigned NUM = 256;
  localparam logic [15:0] SEED_V = 16'hACE1;
  localparam logic [15:0] TAPS_V = 16'hB400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic outReady = 1'b0;
  logic outValid;
  logic [31:0] outData;
  logic streamDone;

  int total = 0;
  int bad = 0;
  bit wdFired = 0;

  always #2.5 clk = ~clk;

  stim_source u_stim_source (
    .clk(clk), .rstN(rstN), .outValid(outValid), .outReady(outReady),
    .outData(outData), .streamDone(streamDone)
  );

  function automatic logic [15:0] galoisStep(logic [15:0] s);
    logic [15:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ TAPS_V;
    return n;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive a stream; stop after stopAt accepts (stopAt==NUM runs to completion)
  task automatic runStream(int stopAt);
    logic [15:0] expData = SEED_V;
    int accepted = 0;
    int cyc = 0;
    logic prevStall = 0;
    logic [31:0] prevData = '0;
    bit rdy;
    while (accepted < stopAt && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      check(outValid == 1'b1, "R9/R6 valid while stream live", {31'b0, outValid}, 32'd1);
      check(outData == {16'b0, expData}, (accepted == 0) ? "R2 first payload" : "R3/R5 payload",
            outData, {16'b0, expData});
      if (prevStall) check(outData == prevData, "R4 data held under stall", outData, prevData);
      if (cyc <= 12) rdy = 0;                       // directed long stall on first message
      else if (accepted < 40) rdy = ($urandom % 5) != 0;
      else if (accepted < 120) rdy = 1;
      else rdy = ($urandom % 2) != 0;
      outReady = rdy;
      prevStall = outValid && !rdy;
      prevData = outData;
      if (rdy && outValid) begin
        expData = galoisStep(expData);
        accepted++;
      end
      check(streamDone == 1'b0, "R7 done low mid-stream", {31'b0, streamDone}, 32'd0);
    end
    if (cyc >= 20000) wdFired = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    #1;
    check(outValid == 1'b0, "R1 valid low in reset", {31'b0, outValid}, 32'd0);
    check(streamDone == 1'b0, "R1 done low in reset", {31'b0, streamDone}, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9: one edge after release valid appears
    runStream(NUM);
    @(negedge clk);
    check(streamDone == 1'b1, "R7 done after last accept", {31'b0, streamDone}, 32'd1);
    check(outValid == 1'b0, "R6 no offer after count", {31'b0, outValid}, 32'd0);
    outReady = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R6 ready ignored after done", {31'b0, outValid}, 32'd0);
      check(streamDone == 1'b1, "R7 done sticky", {31'b0, streamDone}, 32'd1);
    end
    // R8: restart, partial stream, asynchronous reset mid-stream
    outReady = 1'b0;
    rstN = 1'b0;
    #1;
    check(streamDone == 1'b0, "R1 done cleared by reset", {31'b0, streamDone}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    runStream(30);
    #1.2;
    rstN = 1'b0;   // asynchronous, away from an edge
    #0.3;
    check(outValid == 1'b0, "R1 async clear of valid", {31'b0, outValid}, 32'd0);
    outReady = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    runStream(NUM);
    @(negedge clk);
    check(streamDone == 1'b1, "R8 restarted stream completes", {31'b0, streamDone}, 32'd1);
    if (wdFired) check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule